// File: doc/BRIEF.md
# SPI Flash Identification and Status Responder

This block is the command layer of the slave side of a serial NOR flash. A separate bit shifter delivers each complete byte from the host as `mosi_byte`, with a one-cycle `byte_vld` strobe. The chip-select level `cs_n` frames the transaction. On each strobe the responder registers the byte that the shifter must send back in the next byte slot. Slot 1 is the opcode, and every later byte advances the slot by one.

The responder answers three identification reads:
- a three-byte identity read (manufacturer, memory type, device);
- a manufacturer/device read that takes two dummy bytes and a selector byte, where the selector picks the order of the reply;
- a device-ID read that leaves the power-down state and takes three dummy bytes.

It also answers a status read that repeats for as long as the device stays selected. It keeps an 8-bit status register. A write-enable command and a write-disable command set and clear the write-enable latch. A write-status command changes the upper six bits of the register, and only when the host deselects the device. Bit 0 follows the `wip_in` busy input from the program and erase engine. A hardware write-protect input `wp_n` can lock the register.

Top module: `spiid_responder`

## Requirements
- R1: After reset, `miso_byte` is 0xFF. The status register reads back as 0x00, except bit 0, which always follows `wip_in`.
- R2: Identity read, opcode 0x9F. The replies for slots 2, 3 and 4 are MFR_ID, MEM_TYPE and DEV_ID in that order. Slots 5 and later return 0xFF.
- R3: Manufacturer/device read, opcode 0x90. Slots 2 to 4 return 0xFF, because the host sends two dummy bytes and then a selector in slot 4. If bit 0 of the selector is 0, slot 5 returns MFR_ID and slot 6 returns DEV_ID. If bit 0 is 1, the two are swapped. Slot 7 and later return 0xFF.
- R4: Device-ID read, opcode 0xAB. Slots 2 to 4 (three dummy bytes) return 0xFF. Slot 5 returns DEV_ID. Slots 6 and later return 0xFF.
- R5: Status read, opcode 0x05. Every slot from 2 on returns the status value held when the previous byte was strobed. The layout is: bit 0 busy, bit 1 write-enable latch, bits 5:2 protect level, bit 6 continuous-program flag, bit 7 register lock.
- R6: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it.
- R7: Write status, opcode 0x01. Bits 7:2 of the first data byte are loaded into status bits 7:2 when `cs_n` rises. A second data byte is accepted and has no effect. The write-enable latch is clear after any write-status that carried at least one data byte.
- R8: A write-status is ignored in three cases: the write-enable latch is clear, status bit 7 is set while `wp_n` is low, or no data byte was sent.
- R9: Unrecognised opcodes return 0xFF in every slot. `miso_byte` is 0xFF in the cycle after any cycle with `cs_n` high.
- R10: While the device is selected, `miso_byte` changes only on a `byte_vld` strobe. A change of `wip_in` between strobes does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip-select level, low while selected |
| byte_vld | input | 1 | One-cycle strobe: `mosi_byte` holds a complete host byte |
| mosi_byte | input | 8 | Byte received from the host |
| wip_in | input | 1 | Busy flag from the program/erase engine, shown as status bit 0 |
| wp_n | input | 1 | Write-protect pin, low to honour the register lock |
| miso_byte | output | 8 | Byte to send in the next byte slot |

## Verification
A wrong slot count or a latched opcode shows up at `miso_byte` one strobe later. An ID byte lands in the wrong slot, or a dummy slot returns data instead of 0xFF. A wrong order selector swaps the fifth and sixth bytes of the manufacturer/device read. A corrupted status register, such as a write applied without the latch or a latch left set, does not appear until the next status read. Every write scenario is therefore followed straight away by a status read, so the error surfaces within one short transaction.

// File: rtl/spiid_pkg.sv
package spiid_pkg;

    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_MFDV   = 8'h90;
    localparam logic [7:0] OP_WAKEID = 8'hAB;
    localparam logic [7:0] OP_RDST   = 8'h05;
    localparam logic [7:0] OP_WRST   = 8'h01;
    localparam logic [7:0] OP_WEN    = 8'h06;
    localparam logic [7:0] OP_WDIS   = 8'h04;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_IDENT, CMD_MFDV, CMD_WAKEID,
        CMD_RDST, CMD_WRST, CMD_WEN, CMD_WDIS
    } cmd_e;

    typedef struct packed {
        logic       lock;
        logic       cprog;
        logic [3:0] prot;
        logic       wel;
        logic       busy;
    } stat_t;

    typedef struct packed {
        logic       set_wel;
        logic       clr_wel;
        logic       load;
        logic [7:0] data;
        logic       commit;
    } sr_evt_t;

    function automatic cmd_e decode_op(logic [7:0] op);
        case (op)
            OP_IDENT:  return CMD_IDENT;
            OP_MFDV:   return CMD_MFDV;
            OP_WAKEID: return CMD_WAKEID;
            OP_RDST:   return CMD_RDST;
            OP_WRST:   return CMD_WRST;
            OP_WEN:    return CMD_WEN;
            OP_WDIS:   return CMD_WDIS;
            default:   return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spiid_status.sv
module spiid_status
    import spiid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wip_in,
    input  logic    wp_n,
    input  sr_evt_t evt,
    output stat_t   stat
);

    logic       wel_q;
    logic [5:0] upper_q;
    logic [5:0] pend_q;
    logic       allow;

    assign allow = wel_q && !(upper_q[5] && !wp_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q   <= 1'b0;
            upper_q <= '0;
            pend_q  <= '0;
        end else begin
            if (evt.load)
                pend_q <= evt.data[7:2];
            if (evt.commit) begin
                if (allow)
                    upper_q <= pend_q;
                wel_q <= 1'b0;
            end else if (evt.set_wel) begin
                wel_q <= 1'b1;
            end else if (evt.clr_wel) begin
                wel_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat.lock  = upper_q[5];
        stat.cprog = upper_q[4];
        stat.prot  = upper_q[3:0];
        stat.wel   = wel_q;
        stat.busy  = wip_in;
    end

    // R6
    wel_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.set_wel && !evt.commit) |=> wel_q);

    // R6
    wel_clr_chk: assert property (@(posedge clk) disable iff (rst)
        evt.clr_wel |=> !wel_q);

    // R7
    wel_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        evt.commit |=> !wel_q);

    // R8
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.commit && !wel_q) |=> $stable(upper_q));

    // R8
    no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.commit |=> $stable(upper_q));

endmodule

// File: rtl/spiid_seq.sv
module spiid_seq
    import spiid_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h17,
    parameter int         SLOT_W   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       byte_vld,
    input  logic [7:0] mosi_byte,
    input  stat_t      stat,
    output logic [7:0] miso_byte,
    output sr_evt_t    evt
);

    localparam int              IDX_W   = SLOT_W + 1;
    localparam logic [SLOT_W-1:0] CNT_MAX = '1;

    logic [SLOT_W-1:0] cnt_q;
    cmd_e              cmd_q;
    logic              devfirst_q;
    logic              cs_n_q;
    logic              wrdata_q;
    logic [7:0]        miso_q;

    logic [IDX_W-1:0]  slot;
    logic [IDX_W-1:0]  nxt;
    cmd_e              cmd_now;
    logic              devfirst_now;
    logic              strobe;
    logic [7:0]        reply;

    assign strobe       = byte_vld && !cs_n;
    assign slot         = IDX_W'(cnt_q) + IDX_W'(1);
    assign nxt          = slot + IDX_W'(1);
    assign cmd_now      = (cnt_q == '0) ? decode_op(mosi_byte) : cmd_q;
    assign devfirst_now = (cmd_now == CMD_MFDV && slot == IDX_W'(4)) ?
                          mosi_byte[0] : devfirst_q;

    always_comb begin
        reply = IDLE_BYTE;
        case (cmd_now)
            CMD_IDENT: begin
                if (nxt == IDX_W'(2))      reply = MFR_ID;
                else if (nxt == IDX_W'(3)) reply = MEM_TYPE;
                else if (nxt == IDX_W'(4)) reply = DEV_ID;
            end
            CMD_MFDV: begin
                if (nxt == IDX_W'(5))      reply = devfirst_now ? DEV_ID : MFR_ID;
                else if (nxt == IDX_W'(6)) reply = devfirst_now ? MFR_ID : DEV_ID;
            end
            CMD_WAKEID: begin
                if (nxt == IDX_W'(5))      reply = DEV_ID;
            end
            CMD_RDST:  reply = stat;
            default:   reply = IDLE_BYTE;
        endcase
    end

    always_comb begin
        evt.set_wel = strobe && (cnt_q == '0) && (cmd_now == CMD_WEN);
        evt.clr_wel = strobe && (cnt_q == '0) && (cmd_now == CMD_WDIS);
        evt.load    = strobe && (cnt_q == SLOT_W'(1)) && (cmd_q == CMD_WRST);
        evt.data    = mosi_byte;
        evt.commit  = cs_n && !cs_n_q && (cmd_q == CMD_WRST) && wrdata_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cmd_q      <= CMD_NONE;
            devfirst_q <= 1'b0;
            cs_n_q     <= 1'b1;
            wrdata_q   <= 1'b0;
            miso_q     <= IDLE_BYTE;
        end else begin
            cs_n_q <= cs_n;
            if (cs_n) begin
                cnt_q      <= '0;
                cmd_q      <= CMD_NONE;
                devfirst_q <= 1'b0;
                wrdata_q   <= 1'b0;
                miso_q     <= IDLE_BYTE;
            end else if (byte_vld) begin
                if (cnt_q != CNT_MAX)
                    cnt_q <= cnt_q + SLOT_W'(1);
                if (cnt_q == '0)
                    cmd_q <= cmd_now;
                devfirst_q <= devfirst_now;
                if (evt.load)
                    wrdata_q <= 1'b1;
                miso_q <= reply;
            end
        end
    end

    assign miso_byte = miso_q;

    // R9
    idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> miso_byte == IDLE_BYTE);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !byte_vld) |=> $stable(miso_byte));

    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && cnt_q == '0 && cmd_now == CMD_NONE) |=> miso_byte == IDLE_BYTE);

    // R7
    single_event_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({evt.set_wel, evt.clr_wel, evt.load, evt.commit}) <= 1);

endmodule

// File: rtl/spiid_responder.sv
module spiid_responder
    import spiid_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hC2,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] DEV_ID   = 8'h17
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       byte_vld,
    input  logic [7:0] mosi_byte,
    input  logic       wip_in,
    input  logic       wp_n,
    output logic [7:0] miso_byte
);

    stat_t   stat;
    sr_evt_t evt;

    spiid_seq #(
        .MFR_ID  (MFR_ID),
        .MEM_TYPE(MEM_TYPE),
        .DEV_ID  (DEV_ID),
        .SLOT_W  (3)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .byte_vld (byte_vld),
        .mosi_byte(mosi_byte),
        .stat     (stat),
        .miso_byte(miso_byte),
        .evt      (evt)
    );

    spiid_status u_status (
        .clk   (clk),
        .rst   (rst),
        .wip_in(wip_in),
        .wp_n  (wp_n),
        .evt   (evt),
        .stat  (stat)
    );

endmodule

// File: tb/tb_spiid_responder.sv
module tb_spiid_responder;

    localparam logic [7:0] MFR = 8'hC2;
    localparam logic [7:0] MTY = 8'h20;
    localparam logic [7:0] DEV = 8'h17;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] mosi_byte = 8'h00;
    logic       wip_in = 1'b0;
    logic       wp_n = 1'b1;
    logic [7:0] miso_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [5:0] m_hi  = '0;
    logic       m_wel = 1'b0;

    always #2 clk = ~clk;

    spiid_responder #(.MFR_ID(MFR), .MEM_TYPE(MTY), .DEV_ID(DEV)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld),
        .mosi_byte(mosi_byte), .wip_in(wip_in), .wp_n(wp_n),
        .miso_byte(miso_byte)
    );

    function automatic logic [7:0] exp_st();
        return {m_hi, m_wel, wip_in};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic sel();
        @(negedge clk) cs_n = 1'b0;
    endtask

    task automatic desel();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        @(negedge clk);
        byte_vld  = 1'b1;
        mosi_byte = b;
        @(negedge clk);
        byte_vld  = 1'b0;
        r = miso_byte;
    endtask

    task automatic rd_status(input string req);
        logic [7:0] r;
        sel();
        xfer(8'h05, r);
        check(req, r, exp_st());
        desel();
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, r);
        desel();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic wr_status(input logic [7:0] d0, input bit two, input logic [7:0] d1);
        logic [7:0] r;
        sel();
        xfer(8'h01, r);
        xfer(d0, r);
        check("R7 wrst data slot", r, 8'hFF);
        if (two) xfer(d1, r);
        desel();
        if (m_wel && !(m_hi[5] && !wp_n)) m_hi = d0[7:2];
        m_wel = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] e2;
        logic [7:0] e3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 miso after reset", miso_byte, 8'hFF);
        rd_status("R1 status after reset");

        // R9 R2 R5 R6: sweep all opcodes, look at slots 2 and 3
        for (int op = 0; op < 256; op++) begin
            e2 = (op == 8'h9F) ? MFR : (op == 8'h05) ? exp_st() : 8'hFF;
            e3 = (op == 8'h9F) ? MTY : (op == 8'h05) ? exp_st() : 8'hFF;
            sel();
            xfer(8'(op), r);
            check("R9 opcode sweep slot2", r, e2);
            xfer(8'h00, r);
            check("R9 opcode sweep slot3", r, e3);
            desel();
            if (op == 8'h06) m_wel = 1'b1;
            if (op == 8'h04) m_wel = 1'b0;
            check("R9 miso idle after deselect", miso_byte, 8'hFF);
        end
        one_op(8'h04);

        // R2 full identity read
        sel();
        xfer(8'h9F, r); check("R2 slot2", r, MFR);
        xfer(8'h00, r); check("R2 slot3", r, MTY);
        xfer(8'h00, r); check("R2 slot4", r, DEV);
        xfer(8'h00, r); check("R2 slot5", r, 8'hFF);
        xfer(8'h00, r); check("R2 slot6", r, 8'hFF);
        desel();

        // R3 selector sweep
        for (int s = 0; s < 6; s++) begin
            logic [7:0] sv;
            sv = (s < 4) ? 8'(s) : ((s == 4) ? 8'hFE : 8'hFF);
            sel();
            xfer(8'h90, r); check("R3 slot2", r, 8'hFF);
            xfer(8'hA5, r); check("R3 slot3", r, 8'hFF);
            xfer(8'h5A, r); check("R3 slot4", r, 8'hFF);
            xfer(sv, r);    check("R3 slot5", r, sv[0] ? DEV : MFR);
            xfer(8'h00, r); check("R3 slot6", r, sv[0] ? MFR : DEV);
            xfer(8'h00, r); check("R3 slot7", r, 8'hFF);
            desel();
        end

        // R4 wake/device-ID read
        sel();
        xfer(8'hAB, r); check("R4 slot2", r, 8'hFF);
        xfer(8'h00, r); check("R4 slot3", r, 8'hFF);
        xfer(8'h00, r); check("R4 slot4", r, 8'hFF);
        xfer(8'h00, r); check("R4 slot5", r, DEV);
        xfer(8'h00, r); check("R4 slot6", r, 8'hFF);
        desel();

        // R5 streaming status with busy toggling; R10 hold between strobes
        sel();
        xfer(8'h05, r); check("R5 stream first", r, exp_st());
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) wip_in = i[0];
            xfer(8'h00, r); check("R5 stream byte", r, exp_st());
        end
        e2 = r;
        @(negedge clk) wip_in = ~wip_in;
        repeat (3) @(negedge clk);
        check("R10 hold without strobe", miso_byte, e2);
        desel();
        wip_in = 1'b0;

        // R8 write without latch is ignored
        wr_status(8'hFC, 1'b0, 8'h00);
        rd_status("R8 write without latch");

        // R6 latch set visible, R7 write with second byte ignored
        one_op(8'h06);
        rd_status("R6 latch set");
        wr_status(8'h3C, 1'b1, 8'hC0);
        rd_status("R7 write applied and latch cleared");

        // R6 write-disable then write is ignored
        one_op(8'h06);
        one_op(8'h04);
        rd_status("R6 latch cleared");
        wr_status(8'h44, 1'b0, 8'h00);
        rd_status("R8 write after disable ignored");

        // R8 opcode-only write status does nothing
        one_op(8'h06);
        one_op(8'h01);
        rd_status("R8 opcode-only write no effect");
        one_op(8'h04);

        // R8 lock with write-protect pin
        one_op(8'h06);
        wr_status(8'h80, 1'b0, 8'h00);
        rd_status("R7 lock bit written");
        wp_n = 1'b0;
        one_op(8'h06);
        wr_status(8'h08, 1'b0, 8'h00);
        rd_status("R8 locked while protected");
        wp_n = 1'b1;
        one_op(8'h06);
        wr_status(8'h54, 1'b0, 8'h00);
        rd_status("R8 lock released by pin high");

        // R1 busy follows input
        wip_in = 1'b1;
        rd_status("R1 busy bit follows input");
        wip_in = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule